// File: doc/BRIEF.md
# Two-Key Write-Protect Unlock Gate

This block guards a bank of configuration registers against stray writes. Out of reset the bank is locked. Software opens it by writing two key bytes to one dedicated key register: first 0xCA, then 0x53. The unlock takes effect on the clock edge that captures the second key. Any other write to the key register closes the bank again, and so does a first key written twice.

The block watches the same write strobe, address and data that feed the protected registers. It outputs a registered unlock flag. For every write it also outputs a per-write decision. A write aimed at a protected offset is either granted, so the register may capture it, or blocked, so the register must drop it. Writes to other offsets pass by without affecting the key sequence.

Top module: `wp_unlock_gate`

## Requirements
- R1: A synchronous active-high reset puts the gate in the locked state. While it is locked, `unlocked` is 0 and no protected write is granted.
- R2: A write of key byte 0xCA followed by a key-register write of 0x53 unlocks the bank. `unlocked` rises on the edge that captures 0x53, so a protected write in the very next cycle is granted.
- R3: Only bits [7:0] of `wr_data` take part in key comparison. Bits [31:8] have no effect on the sequence.
- R4: After 0xCA, the next key-register write returns the gate to locked unless its byte is 0x53. This includes a second 0xCA.
- R5: While unlocked, any key-register write relocks the gate. This includes 0xFF, 0xCA and 0x53.
- R6: Writes to addresses other than the key register, and cycles with `wr_en` low, leave the sequence state unchanged, whether it is locked, armed or unlocked.
- R7: A write to a protected offset is reported in the same cycle. It raises `wr_grant` if the gate is unlocked and `wr_block` otherwise, and never raises both.
- R8: The key register is at byte offset 0x24. The protected offsets are 0x00, 0x04, 0x0C, 0x10 and 0x18, and address bits [1:0] are ignored. Writes to any other offset, or to the key register, raise neither `wr_grant` nor `wr_block`.
- R9: A 0x53 written to the key register while the gate is locked leaves it locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data; the key byte is bits [7:0] |
| unlocked | output | 1 | Registered flag: protected bank is writable |
| wr_grant | output | 1 | Current write targets a protected offset and is accepted |
| wr_block | output | 1 | Current write targets a protected offset and is refused |

## Verification
A wrong sequence state shows up at the ports only through `unlocked` and the grant/block pair. An armed-versus-locked mix-up stays hidden until the next key write, so the bench follows every first key with every kind of second write. A state that opens too early or stays open too long shows up within one cycle as a granted protected write where a block was expected. To catch this, protected writes are interleaved with key writes throughout the random phase. Directed runs cover the doubled first key, a lone second key, upper data bits, and writes to other addresses between the two keys.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        WP_LOCKED = 2'd0,
        WP_ARMED  = 2'd1,
        WP_OPEN   = 2'd2
    } wp_state_e;

    localparam logic [7:0] WP_KEY_FIRST  = 8'hCA;
    localparam logic [7:0] WP_KEY_SECOND = 8'h53;

    typedef struct packed {
        logic       valid;
        logic       key_hit;
        logic       prot_hit;
        logic [7:0] key_byte;
    } wp_wr_s;

    // Next sequence state after a key-register write carrying byte b.
    function automatic wp_state_e wp_next(wp_state_e cur, logic [7:0] b);
        case (cur)
            WP_LOCKED: return (b == WP_KEY_FIRST)  ? WP_ARMED : WP_LOCKED;
            WP_ARMED:  return (b == WP_KEY_SECOND) ? WP_OPEN  : WP_LOCKED;
            default:   return WP_LOCKED;
        endcase
    endfunction

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
    import wp_pkg::*;
#(
    parameter int unsigned    ADDR_W   = 8,
    parameter int unsigned    DATA_W   = 32,
    parameter int unsigned    KEY_ADDR = 'h24,
    parameter logic [63:0]    PROT_MAP = 64'h5B
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wp_wr_s            wr_info
);
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned WORDS    = 2 ** WORD_W;
    localparam int unsigned KEY_WORD = KEY_ADDR >> 2;

    logic [WORD_W-1:0] word_idx;
    logic [WORDS-1:0]  prot_vec;

    assign word_idx = wr_addr[ADDR_W-1:2];

    // Expand the protection map over the decoded word space.
    for (genvar w = 0; w < WORDS; w++) begin : g_map
        if (w < 64 && w != KEY_WORD) begin : g_use
            assign prot_vec[w] = PROT_MAP[w];
        end else begin : g_off
            assign prot_vec[w] = 1'b0;
        end
    end

    always_comb begin
        wr_info          = '0;
        wr_info.valid    = wr_en;
        wr_info.key_hit  = wr_en && (int'(word_idx) == KEY_WORD);
        wr_info.prot_hit = wr_en && prot_vec[word_idx];
        wr_info.key_byte = wr_data[7:0];
    end

endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq
    import wp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wp_wr_s    wr_info,
    output wp_state_e state,
    output logic      unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WP_LOCKED;
        end else if (wr_info.key_hit) begin
            state <= wp_next(state, wr_info.key_byte);
        end
    end

    assign unlocked = (state == WP_OPEN);

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == WP_LOCKED)); // R1

    AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(wr_info.key_hit) && $past(wr_info.key_byte) == WP_KEY_SECOND
                             && $past(state) == WP_ARMED)); // R2

    AST_ARMED_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (state == WP_ARMED && wr_info.key_hit && wr_info.key_byte != WP_KEY_SECOND)
        |=> (state == WP_LOCKED)); // R4

    AST_OPEN_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (state == WP_OPEN && wr_info.key_hit) |=> (state == WP_LOCKED)); // R5

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        !wr_info.key_hit |=> $stable(state)); // R6

    AST_LOCKED_SECOND: assert property (@(posedge clk) disable iff (rst)
        (state == WP_LOCKED && wr_info.key_hit && wr_info.key_byte == WP_KEY_SECOND)
        |=> (state == WP_LOCKED)); // R9

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
    import wp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wp_wr_s wr_info,
    input  logic   unlocked,
    output logic   wr_grant,
    output logic   wr_block
);
    always_comb begin
        wr_grant = 1'b0;
        wr_block = 1'b0;
        if (wr_info.prot_hit) begin
            if (unlocked) wr_grant = 1'b1;
            else          wr_block = 1'b1;
        end
    end

    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_grant, wr_block})); // R7

    AST_GRANT_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> unlocked); // R7

    AST_KEY_NOT_GATED: assert property (@(posedge clk) disable iff (rst)
        wr_info.key_hit |-> !(wr_grant || wr_block)); // R8

endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned KEY_ADDR = 'h24,
    parameter logic [63:0] PROT_MAP = 64'h5B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked,
    output logic              wr_grant,
    output logic              wr_block
);
    wp_wr_s    wr_info;
    wp_state_e seq_state;

    wp_addr_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_ADDR (KEY_ADDR),
        .PROT_MAP (PROT_MAP)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_info (wr_info)
    );

    wp_key_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_info  (wr_info),
        .state    (seq_state),
        .unlocked (unlocked)
    );

    wp_write_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .wr_info  (wr_info),
        .unlocked (unlocked),
        .wr_grant (wr_grant),
        .wr_block (wr_block)
    );

    AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (seq_state != WP_OPEN) |-> !wr_grant); // R1

endmodule

// File: tb/test_wp_unlock_gate.sv
module test_wp_unlock_gate;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        unlocked, wr_grant, wr_block;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m = 0; // 0 locked, 1 armed, 2 open

    always #(CLK_P/2) clk = ~clk;

    wp_unlock_gate i_wp_unlock_gate (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unlocked(unlocked), .wr_grant(wr_grant), .wr_block(wr_block)
    );

    function automatic bit is_key(logic [7:0] a);
        return a[7:2] == 6'd9;
    endfunction

    function automatic bit is_prot(logic [7:0] a);
        int w = int'(a[7:2]);
        return (w == 0) || (w == 1) || (w == 3) || (w == 4) || (w == 6);
    endfunction

    function automatic int next_m(int s, bit en, logic [7:0] a, logic [31:0] d);
        if (!(en && is_key(a))) return s;
        if (s == 0) return (d[7:0] == 8'hCA) ? 1 : 0;
        if (s == 1) return (d[7:0] == 8'h53) ? 2 : 0;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, check outputs before the edge, then advance the model.
    task automatic step(bit en, logic [7:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        #1;
        chk({tag, " unlocked"}, int'(unlocked), (m == 2) ? 1 : 0);
        chk({(en && is_prot(a)) ? "R7" : "R8", " grant"}, int'(wr_grant),
            (en && is_prot(a) && m == 2) ? 1 : 0);
        chk({(en && is_prot(a)) ? "R7" : "R8", " block"}, int'(wr_block),
            (en && is_prot(a) && m != 2) ? 1 : 0);
        m = next_m(m, en, a, d);
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [10] = '{8'h24, 8'h00, 8'h04, 8'h0C, 8'h10, 8'h18,
                                   8'h08, 8'h40, 8'h26, 8'h13};
        void'($urandom(32'd2024));
        do_reset();
        // R1: reset state, protected write refused
        step(1, 8'h00, 32'h1, "R1");
        step(1, 8'h18, 32'h1, "R1");
        // R2: unlock then protected write next cycle
        step(1, 8'h24, 32'hCA, "R2");
        step(1, 8'h24, 32'h53, "R2");
        step(1, 8'h04, 32'h5, "R2");
        chk("R2 open", int'(unlocked), 1);
        // R8: unprotected and key writes never gated
        step(1, 8'h08, 32'h0, "R8");
        // R5: 0xFF relocks
        step(1, 8'h24, 32'hFF, "R5");
        step(1, 8'h10, 32'h0, "R5");
        // R5: 0xCA while open relocks
        step(1, 8'h24, 32'hCA, "R5");
        step(1, 8'h24, 32'h53, "R5");
        step(1, 8'h24, 32'hCA, "R5");
        step(1, 8'h0C, 32'h0, "R5");
        // R4: doubled first key
        step(1, 8'h24, 32'hCA, "R4");
        step(1, 8'h24, 32'hCA, "R4");
        step(1, 8'h24, 32'h53, "R4");
        step(1, 8'h00, 32'h0, "R4");
        // R9: lone second key
        step(1, 8'h24, 32'h53, "R9");
        step(0, 8'h00, 32'h0, "R9");
        // R3: upper bits ignored
        step(1, 8'h24, 32'h1234_56CA, "R3");
        step(1, 8'h27, 32'hFFFF_FF53, "R3");
        step(1, 8'h00, 32'h0, "R3");
        chk("R3 open", int'(unlocked), 1);
        step(1, 8'h24, 32'hCA00_0000, "R3");
        // R6: other writes and idle between keys
        step(1, 8'h24, 32'hCA, "R6");
        step(1, 8'h04, 32'hCA, "R6");
        step(0, 8'h24, 32'hFF, "R6");
        step(1, 8'h40, 32'h53, "R6");
        step(1, 8'h24, 32'h53, "R6");
        step(1, 8'h18, 32'h0, "R6");
        // R1: mid-run reset while open
        do_reset();
        step(1, 8'h00, 32'h0, "R1");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            int dsel = $urandom_range(0, 5);
            logic [31:0] d = $urandom();
            if (dsel == 0) d[7:0] = 8'hCA;
            else if (dsel == 1) d[7:0] = 8'h53;
            else if (dsel == 2) d[7:0] = 8'hFF;
            if (sel < 3) sel = 0; // bias toward the key register
            step(($urandom_range(0, 7) != 0), addrs[sel], d, "R6");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule